// File: doc/BRIEF.md
# DMA Channel Status and Control Register Bank

This block is the shared register bank of a multi-channel DMA controller. It collects per-channel event pulses from the channel engines (transfer done, termination, bus error), keeps them as sticky flags, and combines them with per-channel interrupt enables into one interrupt line per channel. It also holds the per-channel freeze controls and issues one-cycle reset pulses to the channels. Global burst-mode enables for the peripheral bus are kept here as well.

Software reaches the bank over a simple 32-bit register bus with a write strobe and a combinational read. Every register has three write addresses. The base address replaces the value. Base plus 4 ORs the written ones into the register. Base plus 8 clears the bits written as ones. This lets several agents change single bits without a read-modify-write. An event pulse from a channel always takes priority over a software write to the same bit in the same cycle, so no event is lost.

Top module: `dma_chanctl_regs`

## Requirements
- R1: After reset every register reads 0, and all interrupt, freeze, reset pulse and burst outputs are 0.
- R2: The base addresses are 0x00 (config), 0x10 (done flags in bits 15:0, interrupt enables in bits 31:16), 0x20 (error flags in bits 15:0, bus-error type in bits 31:16) and 0x30 (freeze in bits 15:0, reset request in bits 31:16). Any other address reads 0, and a write to it changes nothing.
- R3: A write to base+0 replaces the register, base+4 sets the written ones, and base+8 clears the written ones while leaving other bits unchanged. A read at base+4 or base+8 returns the base register.
- R4: A done pulse on channel n sets done flag n at the next clock edge.
- R5: A termination pulse sets error flag n and clears type bit n. A bus-error pulse sets both. When both pulses arrive together, the bus error is recorded.
- R6: When an event pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R7: Interrupt n is high while (done flag n and enable n) or error flag n holds. It follows register state with no extra delay.
- R8: Freeze output n equals freeze bit n. Clearing the bit resumes the channel.
- R9: Writing 1 to bit 16+n at base+0 or base+4 of 0x30 drives reset output n high for exactly the one cycle after the write edge. The bit reads 1 only in that cycle and clears itself. A clear-alias write does not produce a pulse.
- R10: Config bits 28 and 29 drive the burst enable and 8-beat burst enable outputs. The other config bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| done_evt | input | NCH | Per-channel transfer-done pulse |
| term_evt | input | NCH | Per-channel termination pulse |
| buserr_evt | input | NCH | Per-channel bus-error pulse |
| irq_o | output | NCH | Per-channel interrupt |
| freeze_o | output | NCH | Per-channel freeze level |
| chan_rst_o | output | NCH | Per-channel one-cycle reset pulse |
| burst_en_o | output | 1 | Peripheral bus burst enable |
| burst8_en_o | output | 1 | Peripheral bus 8-beat burst enable |

## Verification
The hardest case to reach is a collision between an event and software. Software clears a flag through the clear alias in the same edge in which a channel raises that flag again. The bench drives a channel pulse and a clear-alias bus write in the same cycle, on both the done flags and the error flags. It then reads the register back to confirm that the event survived. The second hard case is the self-clearing reset request. The bench samples the reset outputs and the read-back value in the single cycle after the write, and again one cycle later.

// File: rtl/dma_chanctl_pkg.sv
package dma_chanctl_pkg;
  localparam int DATA_W     = 32;
  localparam int HI_LSB     = 16;
  localparam int BURST_BIT  = 28;
  localparam int BURST8_BIT = 29;

  typedef enum logic [1:0] {
    REG_CFG   = 2'd0,
    REG_DONE  = 2'd1,
    REG_ERR   = 2'd2,
    REG_CHCTL = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_PLAIN = 2'd1,
    WR_SET   = 2'd2,
    WR_CLR   = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
    wr_kind_e kind;
  } access_t;
endpackage

// File: rtl/dma_chanctl_decode.sv
module dma_chanctl_decode
  import dma_chanctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output access_t           acc
);
  logic upper_zero;
  logic alias_ok;

  assign upper_zero = (bus_addr[ADDR_W-1:6] == '0);
  assign alias_ok   = (bus_addr[1:0] == 2'b00) && (bus_addr[3:2] != 2'b11);

  always_comb begin
    acc.hit  = upper_zero && alias_ok;
    acc.sel  = reg_sel_e'(bus_addr[5:4]);
    acc.kind = WR_NONE;
    if (bus_wr && acc.hit) begin
      unique case (bus_addr[3:2])
        2'b00:   acc.kind = WR_PLAIN;
        2'b01:   acc.kind = WR_SET;
        2'b10:   acc.kind = WR_CLR;
        default: acc.kind = WR_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chanctl_flags.sv
module dma_chanctl_flags
  import dma_chanctl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  wr_kind_e     wr_kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt_set,
  input  logic [W-1:0] evt_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] sw_next;
  logic [W-1:0] q_next;

  always_comb begin
    sw_next = q;
    if (wr_en) begin
      unique case (wr_kind)
        WR_PLAIN: sw_next = wdata;
        WR_SET:   sw_next = q | wdata;
        WR_CLR:   sw_next = q & ~wdata;
        default:  sw_next = q;
      endcase
    end
    // events dominate software in the same cycle
    q_next = evt_set | (sw_next & ~evt_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/dma_chanctl_irq.sv
module dma_chanctl_irq #(
  parameter int NCH = 16
) (
  input  logic [NCH-1:0] done_q,
  input  logic [NCH-1:0] en_q,
  input  logic [NCH-1:0] err_q,
  output logic [NCH-1:0] irq
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign irq[n] = (done_q[n] & en_q[n]) | err_q[n];
  end
endmodule

// File: rtl/dma_chanctl_regs.sv
module dma_chanctl_regs
  import dma_chanctl_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    done_evt,
  input  logic [NCH-1:0]    term_evt,
  input  logic [NCH-1:0]    buserr_evt,
  output logic [NCH-1:0]    irq_o,
  output logic [NCH-1:0]    freeze_o,
  output logic [NCH-1:0]    chan_rst_o,
  output logic              burst_en_o,
  output logic              burst8_en_o
);
  localparam logic [NCH-1:0] NO_EVT = '0;

  access_t        acc;
  logic [NCH-1:0] wd_lo, wd_hi;
  logic [1:0]     wd_cfg;
  logic           we_cfg, we_done, we_err, we_chctl;
  logic [1:0]     cfg_q;
  logic [NCH-1:0] done_q, en_q, err_q, stat_q, frz_q, rst_q;
  logic           unused_wdata;

  dma_chanctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .acc     (acc)
  );

  assign wd_lo        = bus_wdata[NCH-1:0];
  assign wd_hi        = bus_wdata[HI_LSB +: NCH];
  assign wd_cfg       = {bus_wdata[BURST8_BIT], bus_wdata[BURST_BIT]};
  assign unused_wdata = ^bus_wdata;

  assign we_cfg   = (acc.kind != WR_NONE) && (acc.sel == REG_CFG);
  assign we_done  = (acc.kind != WR_NONE) && (acc.sel == REG_DONE);
  assign we_err   = (acc.kind != WR_NONE) && (acc.sel == REG_ERR);
  assign we_chctl = (acc.kind != WR_NONE) && (acc.sel == REG_CHCTL);

  dma_chanctl_flags #(.W(2)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(we_cfg), .wr_kind(acc.kind),
    .wdata(wd_cfg), .evt_set(2'b00), .evt_clr(2'b00), .q(cfg_q)
  );

  dma_chanctl_flags #(.W(NCH)) u_done (
    .clk(clk), .rst_n(rst_n), .wr_en(we_done), .wr_kind(acc.kind),
    .wdata(wd_lo), .evt_set(done_evt), .evt_clr(NO_EVT), .q(done_q)
  );

  dma_chanctl_flags #(.W(NCH)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(we_done), .wr_kind(acc.kind),
    .wdata(wd_hi), .evt_set(NO_EVT), .evt_clr(NO_EVT), .q(en_q)
  );

  dma_chanctl_flags #(.W(NCH)) u_err (
    .clk(clk), .rst_n(rst_n), .wr_en(we_err), .wr_kind(acc.kind),
    .wdata(wd_lo), .evt_set(term_evt | buserr_evt), .evt_clr(NO_EVT), .q(err_q)
  );

  // type bit: bus error sets, a lone termination clears
  dma_chanctl_flags #(.W(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(we_err), .wr_kind(acc.kind),
    .wdata(wd_hi), .evt_set(buserr_evt), .evt_clr(term_evt & ~buserr_evt),
    .q(stat_q)
  );

  dma_chanctl_flags #(.W(NCH)) u_frz (
    .clk(clk), .rst_n(rst_n), .wr_en(we_chctl), .wr_kind(acc.kind),
    .wdata(wd_lo), .evt_set(NO_EVT), .evt_clr(NO_EVT), .q(frz_q)
  );

  // reset requests live for one cycle only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else if (we_chctl && (acc.kind == WR_PLAIN || acc.kind == WR_SET))
      rst_q <= wd_hi;
    else
      rst_q <= '0;
  end

  dma_chanctl_irq #(.NCH(NCH)) u_irq (
    .done_q(done_q), .en_q(en_q), .err_q(err_q), .irq(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc.hit) begin
      unique case (acc.sel)
        REG_CFG: begin
          bus_rdata[BURST_BIT]  = cfg_q[0];
          bus_rdata[BURST8_BIT] = cfg_q[1];
        end
        REG_DONE: begin
          bus_rdata[NCH-1:0]       = done_q;
          bus_rdata[HI_LSB +: NCH] = en_q;
        end
        REG_ERR: begin
          bus_rdata[NCH-1:0]       = err_q;
          bus_rdata[HI_LSB +: NCH] = stat_q;
        end
        REG_CHCTL: begin
          bus_rdata[NCH-1:0]       = frz_q;
          bus_rdata[HI_LSB +: NCH] = rst_q;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign freeze_o    = frz_q;
  assign chan_rst_o  = rst_q;
  assign burst_en_o  = cfg_q[0];
  assign burst8_en_o = cfg_q[1];
endmodule

// File: rtl/dma_chanctl_chk.sv
module dma_chanctl_chk #(
  parameter int NCH    = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NCH-1:0]    done_evt,
  input logic [NCH-1:0]    term_evt,
  input logic [NCH-1:0]    buserr_evt,
  input logic [NCH-1:0]    irq_o,
  input logic [NCH-1:0]    freeze_o,
  input logic [NCH-1:0]    chan_rst_o,
  input logic [NCH-1:0]    done_q,
  input logic [NCH-1:0]    err_q,
  input logic [NCH-1:0]    stat_q
);
  logic rst_req_wr;
  assign rst_req_wr = bus_wr && (bus_wdata[16 +: NCH] != '0) &&
                      (bus_addr == ADDR_W'(8'h30) || bus_addr == ADDR_W'(8'h34));

  // R4
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt != '0) |=> ((done_q & $past(done_evt)) == $past(done_evt)));

  // R5
  buserr_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buserr_evt != '0) |=> (((err_q & stat_q) & $past(buserr_evt)) == $past(buserr_evt)));

  // R5
  term_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((term_evt & ~buserr_evt) != '0) |=>
      ((stat_q & $past(term_evt & ~buserr_evt)) == '0));

  // R7
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((term_evt | buserr_evt) != '0) |=>
      ((irq_o & $past(term_evt | buserr_evt)) == $past(term_evt | buserr_evt)));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(freeze_o));

  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_rst_o != '0) && !rst_req_wr) |=> (chan_rst_o == '0));
endmodule

bind dma_chanctl_regs dma_chanctl_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .done_evt(done_evt), .term_evt(term_evt),
  .buserr_evt(buserr_evt), .irq_o(irq_o), .freeze_o(freeze_o),
  .chan_rst_o(chan_rst_o), .done_q(done_q), .err_q(err_q), .stat_q(stat_q)
);

// File: tb/dma_chanctl_regs_tb.sv
module dma_chanctl_regs_tb;
  localparam int NCH = 16;
  localparam int AW  = 8;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           bus_wr = 0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] done_evt = '0, term_evt = '0, buserr_evt = '0;
  logic [NCH-1:0] irq_o, freeze_o, chan_rst_o;
  logic           burst_en_o, burst8_en_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dma_chanctl_regs #(.NCH(NCH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_evt(done_evt),
    .term_evt(term_evt), .buserr_evt(buserr_evt), .irq_o(irq_o),
    .freeze_o(freeze_o), .chan_rst_o(chan_rst_o),
    .burst_en_o(burst_en_o), .burst8_en_o(burst8_en_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset_state;
    rd_chk("R1 cfg", 8'h00, 0);
    rd_chk("R1 done", 8'h10, 0);
    rd_chk("R1 err", 8'h20, 0);
    rd_chk("R1 chctl", 8'h30, 0);
    check("R1 outs", {irq_o, freeze_o}, 0);
    check("R1 rst/burst", {14'd0, burst_en_o, burst8_en_o, chan_rst_o}, 0);
  endtask

  task automatic t_alias;
    wr(8'h10, 32'h0003_00F0);
    rd_chk("R3 plain", 8'h10, 32'h0003_00F0);
    rd_chk("R3 read set alias", 8'h14, 32'h0003_00F0);
    rd_chk("R3 read clr alias", 8'h18, 32'h0003_00F0);
    wr(8'h14, 32'h0001_0001);
    rd_chk("R3 set", 8'h10, 32'h0003_00F1);
    wr(8'h18, 32'h0002_0010);
    rd_chk("R3 clr", 8'h10, 32'h0001_00E1);
    check("R7 done&en", irq_o, 16'h0001);
    wr(8'h10, 0);
    check("R7 cleared", irq_o, 0);
  endtask

  task automatic t_bad_addr;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h52, 32'hFFFF_FFFF);
    rd_chk("R2 ignore cfg", 8'h00, 0);
    rd_chk("R2 ignore done", 8'h10, 0);
    rd_chk("R2 ignore err", 8'h20, 0);
    rd_chk("R2 ignore chctl", 8'h30, 0);
    rd_chk("R2 hole read", 8'h0C, 0);
    check("R2 outs", {freeze_o, irq_o}, 0);
  endtask

  task automatic t_done;
    wr(8'h14, 32'h0008_0000);
    @(negedge clk); done_evt = 16'h0028;
    @(negedge clk); done_evt = 0;
    rd_chk("R4 done flags", 8'h10, 32'h0008_0028);
    check("R7 enabled only", irq_o, 16'h0008);
    wr(8'h18, 32'h0008_0028);
    check("R7 after clear", irq_o, 0);
  endtask

  task automatic t_err;
    @(negedge clk); term_evt = 16'h0044; buserr_evt = 16'h0050;
    @(negedge clk); term_evt = 0; buserr_evt = 0;
    rd_chk("R5 types", 8'h20, 32'h0050_0054);
    check("R7 error irq", irq_o, 16'h0054);
    @(negedge clk); term_evt = 16'h0010;
    @(negedge clk); term_evt = 0;
    rd_chk("R5 term clears type", 8'h20, 32'h0040_0054);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk("R5 cleared", 8'h20, 0);
    check("R7 none", irq_o, 0);
  endtask

  task automatic t_race;
    wr(8'h14, 32'h0000_0003);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h18; bus_wdata = 32'h0000_0003; done_evt = 16'h0002;
    @(negedge clk);
    bus_wr = 0; done_evt = 0;
    rd_chk("R6 done race", 8'h10, 32'h0000_0002);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h28; bus_wdata = 32'h0001_0001; buserr_evt = 16'h0001;
    @(negedge clk);
    bus_wr = 0; buserr_evt = 0;
    rd_chk("R6 err race", 8'h20, 32'h0001_0001);
    wr(8'h10, 0);
    wr(8'h20, 0);
  endtask

  task automatic t_freeze;
    wr(8'h34, 32'h0000_0011);
    check("R8 freeze set", freeze_o, 16'h0011);
    rd_chk("R8 readback", 8'h30, 32'h0000_0011);
    wr(8'h38, 32'h0000_0001);
    check("R8 resume one", freeze_o, 16'h0010);
    wr(8'h30, 0);
    check("R8 resume all", freeze_o, 0);
  endtask

  task automatic t_rst_pulse;
    wr(8'h34, 32'h0004_0000);
    check("R9 pulse", chan_rst_o, 16'h0004);
    rd_chk("R9 bit live", 8'h30, 32'h0004_0000);
    check("R9 no freeze", freeze_o, 0);
    @(negedge clk);
    check("R9 pulse ends", chan_rst_o, 0);
    rd_chk("R9 self clear", 8'h30, 0);
    wr(8'h30, 32'h0001_0003);
    check("R9 plain pulse", chan_rst_o, 16'h0001);
    check("R9 plain freeze", freeze_o, 16'h0003);
    wr(8'h38, 32'hFFFF_0000);
    check("R9 clr no pulse", chan_rst_o, 0);
    check("R9 clr keeps freeze", freeze_o, 16'h0003);
    wr(8'h30, 0);
  endtask

  task automatic t_burst;
    wr(8'h04, 32'h3000_0000);
    check("R10 both", {30'd0, burst8_en_o, burst_en_o}, 3);
    rd_chk("R10 read", 8'h00, 32'h3000_0000);
    wr(8'h08, 32'h1000_0000);
    check("R10 burst off", {30'd0, burst8_en_o, burst_en_o}, 2);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R10 other bits zero", 8'h00, 32'h3000_0000);
    wr(8'h00, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_alias();
    t_bad_addr();
    t_done();
    t_err();
    t_race();
    t_freeze();
    t_rst_pulse();
    t_burst();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule